// File: doc/BRIEF.md
# Serial Instruction Pulse-Count Guard

This block protects the modifying commands of a serial memory against clock noise. While chip select is high, it counts the rising serial-clock edges. Counting starts at the edge that carries the start bit. When chip select falls, the block compares the count with the length the decoded command should have. That length depends on the command, on the organization (8-bit or 16-bit cells) and on the address width of the array.

The block produces a one-cycle verdict strobe and an abort flag. The program-cycle sequencer uses the flag to hold off the self-timed write or erase. A command that changes the array and arrives with too many or too few pulses is vetoed. Read and write-enable style commands always pass.

All inputs are sampled on the system clock. The serial-clock edge and the start bit come in as one-cycle strobes from the shifter. The decoded command and the organization must be stable by the cycle in which chip select is first seen low. There is no streaming interface: every pin is a plain control or status signal.

Top module: `pulse_guard`

## Requirements
- R1: Counting begins with a `start_det` strobe while `cs` is high. That strobe counts as pulse 1. `edge_stb` strobes before it, such as leading zero bits, are not counted.
- R2: In the first cycle in which `cs` is seen low after being high, and only if a start bit was seen in that selection, `verdict_vld` is high for exactly one cycle in the following cycle. With no start bit, no verdict is given.
- R3: For WRITE and WRAL, the expected length is 3 + address bits + data bits. There are ADDR_W address bits in word mode and ADDR_W+1 in byte mode. There are 16 data bits in word mode and 8 in byte mode. With the defaults (ADDR_W=8), byte mode expects 20 and word mode expects 27.
- R4: For ERASE and ERAL, the expected length is 3 + address bits. With the defaults, byte mode expects 12 and word mode expects 11.
- R5: For a modifying command, `abort` is set to 1 with the verdict when the count differs from the expected length, and to 0 when it matches.
- R6: READ, WEN, WDS and the idle code always give `abort` = 0, whatever the count.
- R7: The count saturates at 2^CNT_W-1 (31 with the defaults) and never wraps. A burst of 52 pulses on a byte-mode WRITE is therefore aborted.
- R8: A new `start_det` while `cs` stays high restarts the count at 1.
- R9: When `cs` is low, the count is cleared and the block is disarmed. `abort` keeps its last value until the next verdict. After reset, `verdict_vld` and `abort` are 0.
- R10: `cmd_code` encoding: 0 idle, 1 READ, 2 WEN, 3 WDS, 4 WRITE, 5 ERASE, 6 ERAL, 7 WRAL. Bit 2 marks the modifying commands. `org_word` = 1 selects 16-bit cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select level, synchronized |
| start_det | input | 1 | One-cycle strobe on the serial-clock edge that carries the start bit |
| edge_stb | input | 1 | One-cycle strobe per rising serial-clock edge |
| cmd_code | input | 3 | Decoded command, encoding as in R10 |
| org_word | input | 1 | 1 = 16-bit organization, 0 = 8-bit |
| verdict_vld | output | 1 | One-cycle strobe after the chip-select fall of an armed frame |
| abort | output | 1 | 1 = vetoes the program cycle of the last verdict |

## Verification
The assertions assume the following about the inputs:
- `start_det` and `edge_stb` are single-cycle strobes.
- `cmd_code` and `org_word` are steady in the cycle where the chip-select fall is seen.

The stimulus keeps to these rules. Every strobe lasts one cycle and is followed by an idle cycle. The command and organization are set before chip select rises and are held until after the verdict. The checks on step, saturation and clearing relate the count register to the strobes of the previous cycle. They therefore hold only while the strobes are single cycles.

// File: rtl/pulse_guard_pkg.sv
package pulse_guard_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WEN   = 3'd2,
    CMD_WDS   = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_ERASE = 3'd5,
    CMD_ERAL  = 3'd6,
    CMD_WRAL  = 3'd7
  } cmd_e;

  function automatic logic cmd_modifies(input cmd_e c);
    return c[2];
  endfunction
endpackage

// File: rtl/pulse_guard_counter.sv
module pulse_guard_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             start_det,
  input  logic             edge_stb,
  output logic             armed,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!cs) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (start_det) begin
      armed <= 1'b1;
      cnt   <= CNT_ONE;
    end else if (armed && edge_stb && (cnt != CNT_MAX)) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  AST_CLEAR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (cnt == '0) && !armed); // R9
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && start_det) |=> (cnt == CNT_ONE) && armed); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !start_det && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !start_det && !edge_stb) |=> $stable(cnt)); // R1
endmodule

// File: rtl/pulse_guard_len.sv
module pulse_guard_len
  import pulse_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_B = 8,
  parameter int CNT_W  = 5
) (
  input  cmd_e             cmd,
  input  logic             org_word,
  output logic             modifies,
  output logic [CNT_W-1:0] exp_len
);
  localparam int HDR = 3;
  localparam logic [CNT_W-1:0] LEN_ER_W = CNT_W'(HDR + ADDR_W);
  localparam logic [CNT_W-1:0] LEN_ER_B = CNT_W'(HDR + ADDR_W + 1);
  localparam logic [CNT_W-1:0] LEN_WR_W = CNT_W'(HDR + ADDR_W + 2 * DATA_B);
  localparam logic [CNT_W-1:0] LEN_WR_B = CNT_W'(HDR + ADDR_W + 1 + DATA_B);

  always_comb begin
    modifies = cmd_modifies(cmd);
    unique case (cmd)
      CMD_WRITE, CMD_WRAL: exp_len = org_word ? LEN_WR_W : LEN_WR_B;
      CMD_ERASE, CMD_ERAL: exp_len = org_word ? LEN_ER_W : LEN_ER_B;
      default:             exp_len = '0;
    endcase
  end
endmodule

// File: rtl/pulse_guard_verdict.sv
module pulse_guard_verdict #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             armed,
  input  logic [CNT_W-1:0] cnt,
  input  logic             modifies,
  input  logic [CNT_W-1:0] exp_len,
  output logic             verdict_vld,
  output logic             abort
);
  logic cs_d;
  logic cs_fall;

  assign cs_fall = cs_d & ~cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d        <= 1'b0;
      verdict_vld <= 1'b0;
      abort       <= 1'b0;
    end else begin
      cs_d        <= cs;
      verdict_vld <= cs_fall & armed;
      if (cs_fall && armed) abort <= modifies && (cnt != exp_len);
    end
  end

  AST_VLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> !$past(cs)); // R2
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld); // R2
  AST_READ_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && armed && !modifies) |=> !abort); // R6
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_fall && armed) |=> $stable(abort)); // R9
endmodule

// File: rtl/pulse_guard.sv
module pulse_guard
  import pulse_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_B = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       start_det,
  input  logic       edge_stb,
  input  logic [2:0] cmd_code,
  input  logic       org_word,
  output logic       verdict_vld,
  output logic       abort
);
  localparam int MAX_LEN = 3 + ADDR_W + 2 * DATA_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             modifies;
  logic [CNT_W-1:0] exp_len;

  pulse_guard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cs(cs), .start_det(start_det),
    .edge_stb(edge_stb), .armed(armed), .cnt(cnt)
  );

  pulse_guard_len #(.ADDR_W(ADDR_W), .DATA_B(DATA_B), .CNT_W(CNT_W)) u_len (
    .cmd(cmd_e'(cmd_code)), .org_word(org_word),
    .modifies(modifies), .exp_len(exp_len)
  );

  pulse_guard_verdict #(.CNT_W(CNT_W)) u_vrd (
    .clk(clk), .rst_n(rst_n), .cs(cs), .armed(armed), .cnt(cnt),
    .modifies(modifies), .exp_len(exp_len),
    .verdict_vld(verdict_vld), .abort(abort)
  );

  AST_ABORT_MOD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !$past(cmd_code[2])) |-> !abort); // R6
endmodule

// File: tb/pulse_guard_tb_top.sv
module pulse_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, start_det = 1'b0, edge_stb = 1'b0, org_word = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic verdict_vld, abort;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pulse_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .start_det(start_det),
    .edge_stb(edge_stb), .cmd_code(cmd_code), .org_word(org_word),
    .verdict_vld(verdict_vld), .abort(abort)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one selection: pre leading clocks, restart after rs pulses (0 = none), then n pulses
  task automatic frame(input logic [2:0] c, input logic org, input int pre,
                       input int rs, input int n, input bit with_start);
    @(negedge clk);
    cmd_code = c; org_word = org; cs = 1'b1;
    @(negedge clk);
    for (int i = 0; i < pre; i++) begin
      edge_stb = 1'b1; @(negedge clk); edge_stb = 1'b0; @(negedge clk);
    end
    for (int i = 0; i < rs; i++) begin
      edge_stb = 1'b1; start_det = (i == 0) && with_start;
      @(negedge clk); edge_stb = 1'b0; start_det = 1'b0; @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      edge_stb = 1'b1; start_det = (i == 0) && with_start;
      @(negedge clk); edge_stb = 1'b0; start_det = 1'b0; @(negedge clk);
    end
    cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_verdict(input string req, input logic exp_abort);
    chk({req, " vld"}, verdict_vld, 1'b1);
    chk({req, " abort"}, abort, exp_abort);
    @(negedge clk);
    chk({req, " vld drop"}, verdict_vld, 1'b0);
  endtask

  task automatic t_reset();
    chk("R9 reset vld", verdict_vld, 1'b0);
    chk("R9 reset abort", abort, 1'b0);
  endtask

  task automatic t_write_len();
    frame(3'd4, 1'b0, 0, 0, 20, 1'b1); expect_verdict("R3 write byte 20", 1'b0);
    frame(3'd4, 1'b0, 0, 0, 19, 1'b1); expect_verdict("R5 write byte 19", 1'b1);
    frame(3'd4, 1'b0, 0, 0, 21, 1'b1); expect_verdict("R5 write byte 21", 1'b1);
    frame(3'd4, 1'b1, 0, 0, 27, 1'b1); expect_verdict("R3 write word 27", 1'b0);
    frame(3'd4, 1'b1, 0, 0, 20, 1'b1); expect_verdict("R3 write word 20", 1'b1);
    frame(3'd7, 1'b1, 0, 0, 27, 1'b1); expect_verdict("R3 wral word 27", 1'b0);
    frame(3'd7, 1'b0, 0, 0, 19, 1'b1); expect_verdict("R3 wral byte 19", 1'b1);
  endtask

  task automatic t_erase_len();
    frame(3'd5, 1'b0, 0, 0, 12, 1'b1); expect_verdict("R4 erase byte 12", 1'b0);
    frame(3'd5, 1'b1, 0, 0, 11, 1'b1); expect_verdict("R4 erase word 11", 1'b0);
    frame(3'd5, 1'b0, 0, 0, 11, 1'b1); expect_verdict("R4 erase byte 11", 1'b1);
    frame(3'd6, 1'b0, 0, 0, 12, 1'b1); expect_verdict("R4 eral byte 12", 1'b0);
    frame(3'd6, 1'b1, 0, 0, 12, 1'b1); expect_verdict("R4 eral word 12", 1'b1);
  endtask

  task automatic t_nonmod();
    frame(3'd1, 1'b0, 0, 0, 5, 1'b1); expect_verdict("R6 read 5", 1'b0);
    frame(3'd4, 1'b0, 0, 0, 3, 1'b1); expect_verdict("R10 write short", 1'b1);
    frame(3'd2, 1'b1, 0, 0, 9, 1'b1); expect_verdict("R6 wen 9", 1'b0);
    frame(3'd3, 1'b0, 0, 0, 40, 1'b1); expect_verdict("R6 wds 40", 1'b0);
  endtask

  task automatic t_saturate();
    frame(3'd4, 1'b0, 0, 0, 52, 1'b1); expect_verdict("R7 write 52", 1'b1);
  endtask

  task automatic t_leading();
    frame(3'd4, 1'b0, 3, 0, 20, 1'b1); expect_verdict("R1 lead clocks", 1'b0);
  endtask

  task automatic t_restart();
    frame(3'd5, 1'b0, 0, 7, 12, 1'b1); expect_verdict("R8 restart", 1'b0);
  endtask

  task automatic t_no_start();
    frame(3'd4, 1'b0, 0, 0, 20, 1'b1); expect_verdict("R9 prime", 1'b0);
    frame(3'd4, 1'b0, 0, 0, 7, 1'b0);
    chk("R2 no start vld", verdict_vld, 1'b0);
    @(negedge clk);
    chk("R9 abort held", abort, 1'b0);
    frame(3'd4, 1'b0, 0, 0, 5, 1'b1); expect_verdict("R9 set abort", 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 abort kept", abort, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_len();
    t_erase_len();
    t_nonmod();
    t_saturate();
    t_leading();
    t_restart();
    t_no_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule